// File: doc/BRIEF.md
# Programmable Output Clock Divider Channel

This block is one output channel of a clock generator that has a reference clock and three PLLs. A three-bit selector picks one of seven source clocks: the reference, or either the true or the inverted output of one of the PLLs. The picked clock is divided by a seven-bit integer ratio from 1 to 127. Every ratio, odd or even, gives an output that is high for exactly half of its period.

Two ratio inputs are held side by side, and a pick bit chooses the one in use. Software can therefore stage a new ratio and switch to it without stopping the output. A new ratio is only taken at the end of a high phase, so a switch never produces a shortened pulse. A ratio of zero parks the channel. A control pin, whose meaning is set by a mode bit, can also turn the output off. A PLL that is disabled silences every channel fed from it.

Source clocks are modelled as levels sampled by one fast clock `clk`. The channel counts both edges of the picked source. When the output is off, it reports this on a tri-state flag and drives a data value of 0.

Top module: `outclk_channel`

## Requirements
- R1: With a ratio N from 1 to 127, each high phase and each low phase of `clkOut` lasts N source half-periods, counted as N level changes of the picked source. The output therefore has a 50% duty cycle for odd N as well as even N.
- R2: With N = 1, `clkOut` copies the picked source level and lags it by one `clk` cycle.
- R3: The `srcSel` codes are: 0 reference, 2 PLL0 true, 3 PLL0 inverted, 4 PLL1 true, 5 PLL1 inverted, 6 PLL2 true, 7 PLL2 inverted.
- R4: Code 1 of `srcSel` is reserved. While it is picked, `clkOut` stays 0 and `clkOff` stays 0.
- R5: `divPick` = 0 uses `divA` and `divPick` = 1 uses `divB`. A change of the picked ratio takes effect when a high phase ends. The phase that is running finishes at the old length, and no shortened phase appears.
- R6: A ratio of 0 turns the channel off at the next end of a high phase, or at once if the channel is idle. While it is off, `clkOff` = 1 and `clkOut` = 0.
- R7: If `pllOn` is low for the PLL that `srcSel` picks, `clkOff` = 1 and `clkOut` = 0 from the next sample. The output restarts once `pllOn` returns high.
- R8: With `pinMode` = 1, `ctlPin` low is a shutdown that also resets the divider. With `pinMode` = 0, `ctlPin` high enables the output, and `ctlPin` low gates the output off while the divider keeps running. When gated off, `clkOff` = 1 and `clkOut` = 0.
- R9: While `rstN` is low, `clkOut` = 0 and `clkOff` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast sampling clock |
| rstN | input | 1 | Active-low synchronous reset |
| refSrc | input | 1 | Reference clock level |
| pllSrc | input | 3 | PLL output levels, one bit per PLL |
| pllOn | input | 3 | PLL enables, one bit per PLL |
| srcSel | input | 3 | Source select code |
| divA | input | 7 | Ratio register 0 |
| divB | input | 7 | Ratio register 1 |
| divPick | input | 1 | Chooses the ratio register |
| pinMode | input | 1 | 1: control pin is a shutdown; 0: control pin is an output enable |
| ctlPin | input | 1 | Shared control pin |
| clkOut | output | 1 | Divided clock, 0 while off |
| clkOff | output | 1 | High when the output is tri-stated |

## Verification
Level changes of the source reach `clkOut` one `clk` cycle after the sample in which they appear, through the edge detector and the output register. The bench samples on the falling edge of `clk`, so a divide-by-1 output matches the source value sampled at that same falling edge. Ratio checks measure run lengths between transitions, which keeps them free of that fixed lag. The off conditions that come from PLL enables and from the control pin act through logic with no register in the path. They are checked one sample after the stimulus. A ratio of zero is checked only after the running high phase has ended.

// File: rtl/outclk_pkg.sv
package outclk_pkg;
  typedef struct packed {
    logic hold;   // clear the divider and keep the output low
    logic show;   // let the divided clock reach the pin
  } chanCtl_t;
endpackage

// File: rtl/outclk_srcmux.sv
module outclk_srcmux #(
  parameter int NUM_PLL = 3,
  localparam int NUM_SRC = 2 * NUM_PLL + 2,
  localparam int SEL_W = $clog2(NUM_SRC)
) (
  input  logic               refSrc,
  input  logic [NUM_PLL-1:0] pllSrc,
  input  logic [NUM_PLL-1:0] pllOn,
  input  logic [SEL_W-1:0]   srcSel,
  output logic               srcLvl,
  output logic               srcReserved,
  output logic               srcDead
);
  logic [NUM_SRC-1:0] srcVec;
  logic [NUM_SRC-1:0] deadVec;

  assign srcVec[0]  = refSrc;
  assign srcVec[1]  = 1'b0;
  assign deadVec[0] = 1'b0;
  assign deadVec[1] = 1'b0;

  for (genvar i = 0; i < NUM_PLL; i++) begin : g_pll
    assign srcVec[2*i+2]  = pllSrc[i];
    assign srcVec[2*i+3]  = ~pllSrc[i];
    assign deadVec[2*i+2] = ~pllOn[i];
    assign deadVec[2*i+3] = ~pllOn[i];
  end

  assign srcLvl      = srcVec[srcSel];
  assign srcDead     = deadVec[srcSel];
  assign srcReserved = (srcSel == SEL_W'(1));
endmodule

// File: rtl/outclk_ctrl.sv
module outclk_ctrl
  import outclk_pkg::*;
#(
  parameter int DIV_W = 7
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [DIV_W-1:0] divA,
  input  logic [DIV_W-1:0] divB,
  input  logic             divPick,
  input  logic             pinMode,
  input  logic             ctlPin,
  input  logic             srcReserved,
  input  logic             srcDead,
  input  logic             periodEnd,
  output logic [DIV_W-1:0] activeDiv,
  output chanCtl_t         ctl
);
  logic [DIV_W-1:0] pendingDiv;
  logic shutDown, gateLow, idle;

  assign pendingDiv = divPick ? divB : divA;
  assign shutDown   = pinMode & ~ctlPin;
  assign gateLow    = ~pinMode & ~ctlPin;
  assign idle       = (activeDiv == '0);

  always_comb begin
    ctl.hold = idle | srcReserved | srcDead | shutDown;
    ctl.show = ~(idle | srcDead | shutDown | gateLow);
  end

  always_ff @(posedge clk) begin
    if (!rstN)                       activeDiv <= '0;
    else if (ctl.hold || periodEnd)  activeDiv <= pendingDiv;
  end

  // R5: the ratio in use moves only at a period end or while held
  a_r5_reload_at_boundary: assert property (@(posedge clk) disable iff (!rstN)
    (activeDiv != $past(activeDiv)) |-> ($past(ctl.hold) || $past(periodEnd)));
endmodule

// File: rtl/outclk_datapath.sv
module outclk_datapath
  import outclk_pkg::*;
#(
  parameter int DIV_W = 7
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             srcLvl,
  input  chanCtl_t         ctl,
  input  logic [DIV_W-1:0] activeDiv,
  output logic             outClk,
  output logic             periodEnd
);
  logic             srcPrev;
  logic [DIV_W-1:0] cnt;
  logic             edgeSeen, lastEdge;

  assign edgeSeen  = srcLvl ^ srcPrev;
  assign lastEdge  = edgeSeen && (cnt == activeDiv - DIV_W'(1));
  assign periodEnd = !ctl.hold && lastEdge && outClk;

  always_ff @(posedge clk) begin
    if (!rstN || ctl.hold) begin
      srcPrev <= 1'b0;
      cnt     <= '0;
      outClk  <= 1'b0;
    end else begin
      srcPrev <= srcLvl;
      if (edgeSeen) begin
        if (lastEdge) begin
          cnt    <= '0;
          outClk <= ~outClk;
        end else begin
          cnt <= cnt + DIV_W'(1);
        end
      end
    end
  end

  // R1: the edge count never reaches the ratio in use
  a_r1_count_bound: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.hold |-> (cnt < activeDiv));
  // R1: the output only moves on a source level change
  a_r1_toggle_on_edge: assert property (@(posedge clk) disable iff (!rstN)
    (!$past(ctl.hold) && outClk != $past(outClk)) |-> $past(edgeSeen));
  // R4: a held divider drives a low output
  a_r4_hold_low: assert property (@(posedge clk) disable iff (!rstN)
    ctl.hold |=> !outClk);
endmodule

// File: rtl/outclk_channel.sv
module outclk_channel
  import outclk_pkg::*;
#(
  parameter int DIV_W = 7,
  parameter int NUM_PLL = 3,
  localparam int SEL_W = $clog2(2 * NUM_PLL + 2)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               refSrc,
  input  logic [NUM_PLL-1:0] pllSrc,
  input  logic [NUM_PLL-1:0] pllOn,
  input  logic [SEL_W-1:0]   srcSel,
  input  logic [DIV_W-1:0]   divA,
  input  logic [DIV_W-1:0]   divB,
  input  logic               divPick,
  input  logic               pinMode,
  input  logic               ctlPin,
  output logic               clkOut,
  output logic               clkOff
);
  logic srcLvl, srcReserved, srcDead, outClk, periodEnd;
  logic [DIV_W-1:0] activeDiv;
  chanCtl_t ctl;

  outclk_srcmux #(.NUM_PLL(NUM_PLL)) u_mux (
    .refSrc(refSrc), .pllSrc(pllSrc), .pllOn(pllOn), .srcSel(srcSel),
    .srcLvl(srcLvl), .srcReserved(srcReserved), .srcDead(srcDead));

  outclk_ctrl #(.DIV_W(DIV_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .divA(divA), .divB(divB), .divPick(divPick),
    .pinMode(pinMode), .ctlPin(ctlPin), .srcReserved(srcReserved),
    .srcDead(srcDead), .periodEnd(periodEnd), .activeDiv(activeDiv), .ctl(ctl));

  outclk_datapath #(.DIV_W(DIV_W)) u_dp (
    .clk(clk), .rstN(rstN), .srcLvl(srcLvl), .ctl(ctl),
    .activeDiv(activeDiv), .outClk(outClk), .periodEnd(periodEnd));

  assign clkOut = outClk & ctl.show;
  assign clkOff = ~ctl.show;

  // R7: a disabled PLL silences any channel that picks it
  for (genvar i = 0; i < NUM_PLL; i++) begin : g_chk
    a_r7_dead_pll_off: assert property (@(posedge clk) disable iff (!rstN)
      (srcSel[SEL_W-1:1] == (SEL_W-1)'(i + 1) && !pllOn[i]) |-> (clkOff && !clkOut));
  end
  // R8: an enabled-low pin in either mode keeps the pin dark
  a_r8_pin_off: assert property (@(posedge clk) disable iff (!rstN)
    !ctlPin |-> (clkOff && !clkOut));
endmodule

// File: tb/outclk_channel_tb.sv
module outclk_channel_tb;
  logic clk = 0, rstN = 0, refSrc = 0, divPick = 0, pinMode = 1, ctlPin = 1;
  logic [2:0] pllSrc = '0, pllOn = '1, srcSel = '0;
  logic [6:0] divA = 7'd1, divB = 7'd1;
  logic clkOut, clkOff;
  int checks = 0, fails = 0, cyc = 0;
  int halfCnt [4];
  bit done = 0;

  always #2 clk = ~clk;   // 250 MHz

  outclk_channel u_dut (.clk(clk), .rstN(rstN), .refSrc(refSrc), .pllSrc(pllSrc),
    .pllOn(pllOn), .srcSel(srcSel), .divA(divA), .divB(divB), .divPick(divPick),
    .pinMode(pinMode), .ctlPin(ctlPin), .clkOut(clkOut), .clkOff(clkOff));

  // Source generators: half periods ref 2, PLL0 3, PLL1 4, PLL2 5 cycles
  initial for (int k = 0; k < 4; k++) halfCnt[k] = 0;
  always @(negedge clk) begin
    for (int k = 0; k < 4; k++) begin
      if (halfCnt[k] == k + 1) begin
        halfCnt[k] <= 0;
        if (k == 0) refSrc <= ~refSrc;
        else pllSrc[k-1] <= ~pllSrc[k-1];
      end else halfCnt[k] <= halfCnt[k] + 1;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic waitLevel(input logic lvl);
    for (int i = 0; i < 2000 && clkOut != lvl; i++) @(negedge clk);
  endtask

  task automatic runLen(input logic lvl, output int n);
    n = 0;
    while (clkOut == lvl && n < 2000) begin n++; @(negedge clk); end
  endtask

  task automatic restart(input logic [2:0] sel, input logic [6:0] n);
    @(negedge clk);
    srcSel = sel; divA = n; divPick = 0; pinMode = 1; ctlPin = 0;
    repeat (2) @(negedge clk);
    ctlPin = 1;
  endtask

  task automatic tReset();
    @(negedge clk);
    check(clkOut == 0 && clkOff == 1, "R9 reset state", {clkOut, clkOff}, 1);
    rstN = 1;
  endtask

  task automatic tRatio(input logic [2:0] sel, input logic [6:0] n, input int h, input string tag);
    int hi, lo;
    restart(sel, n);
    waitLevel(0); waitLevel(1); waitLevel(0); waitLevel(1);
    runLen(1, hi); runLen(0, lo);
    check(hi == n * h, {tag, " high phase"}, hi, n * h);
    check(lo == n * h, {tag, " low phase"}, lo, n * h);
  endtask

  task automatic tPass(input logic [2:0] sel, input bit inv, input int idx, input string tag);
    int bad = 0;
    restart(sel, 7'd1);
    repeat (4) @(negedge clk);
    for (int i = 0; i < 40; i++) begin
      logic s;
      s = (idx < 0) ? refSrc : (pllSrc[idx] ^ inv);
      if (clkOut != s) bad++;
      @(negedge clk);
    end
    check(bad == 0, tag, bad, 0);
  endtask

  task automatic tSwitch();
    int a, b, c;
    restart(3'd0, 7'd3);
    divB = 7'd5;
    waitLevel(0); waitLevel(1);
    divPick = 1;   // R5: switch just after a rise
    runLen(1, a); runLen(0, b); runLen(1, c);
    check(a == 6, "R5 running high keeps old ratio", a, 6);
    check(b == 10, "R5 new ratio after boundary (low)", b, 10);
    check(c == 10, "R5 new ratio after boundary (high)", c, 10);
  endtask

  task automatic tZero();
    int a, bad = 0;
    restart(3'd0, 7'd2);
    waitLevel(0); waitLevel(1);
    divA = 7'd0;
    check(clkOff == 0, "R6 stays on until boundary", clkOff, 0);
    runLen(1, a);
    check(a == 4, "R6 last high phase full length", a, 4);
    for (int i = 0; i < 30; i++) begin
      if (!(clkOff == 1 && clkOut == 0)) bad++;
      @(negedge clk);
    end
    check(bad == 0, "R6 zero ratio parks tri-stated", bad, 0);
  endtask

  task automatic tReserved();
    int bad = 0;
    restart(3'd1, 7'd2);
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (clkOut != 0 || clkOff != 0) bad++;
    end
    check(bad == 0, "R4 reserved code held low, not tri-stated", bad, 0);
  endtask

  task automatic tPllDead();
    int hi;
    restart(3'd2, 7'd2);
    waitLevel(1);
    pllOn[0] = 0;
    @(negedge clk);
    check(clkOff == 1 && clkOut == 0, "R7 PLL disable turns output off", {clkOff, clkOut}, 2);
    pllOn[0] = 1;
    @(negedge clk);
    waitLevel(1); runLen(1, hi);
    check(hi == 6, "R7 output resumes after PLL enable", hi, 6);
  endtask

  task automatic tPin();
    restart(3'd0, 7'd2);
    repeat (10) @(negedge clk);
    pinMode = 0; ctlPin = 0;
    @(negedge clk);
    check(clkOff == 1 && clkOut == 0, "R8 enable-mode pin low gates off", {clkOff, clkOut}, 2);
    ctlPin = 1;
    @(negedge clk);
    check(clkOff == 0, "R8 enable-mode pin high on", clkOff, 0);
    pinMode = 1; ctlPin = 0;
    @(negedge clk);
    check(clkOff == 1 && clkOut == 0, "R8 shutdown-mode pin low off", {clkOff, clkOut}, 2);
    ctlPin = 1;
    @(negedge clk);
    check(clkOff == 0, "R8 shutdown-mode pin high on", clkOff, 0);
  endtask

  task automatic finishRun();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    while (cyc < 150000) begin @(posedge clk); cyc++; end
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=0", cyc);
      finishRun();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    tReset();
    tPass(3'd0, 0, -1, "R2 divide-by-1 reference");
    tPass(3'd3, 1, 0, "R2 R3 divide-by-1 PLL0 inverted");
    tRatio(3'd0, 7'd4, 2, "R1 even ratio reference");
    tRatio(3'd2, 7'd3, 3, "R1 odd ratio PLL0");
    tRatio(3'd4, 7'd2, 4, "R3 PLL1 true");
    tRatio(3'd7, 7'd3, 5, "R3 PLL2 inverted");
    tRatio(3'd0, 7'd127, 2, "R1 largest ratio");
    tSwitch();
    tZero();
    tReserved();
    tPllDead();
    tPin();
    done = 1;
    finishRun();
  end
endmodule